// File: doc/BRIEF.md
# Instruction Trace Counter Debug Trigger

This block sits next to a small processor core and decides when the core must stop in debug mode. A debugger programs a trace count and two control bits through a simple write port. It then releases the core with an exit command. If tracing is enabled, the block counts the instructions the core retires, including those run inside interrupt handlers. When the programmed budget is used up, it raises a debug request and flags that the stop came from tracing.

A loaded count of N lets N+1 instructions run before the stop. A count of zero is accepted only while sequential-breakpoint operation is on, and then exactly one instruction runs. The block can also park the core in debug mode straight out of a core reset, so that nothing executes before the debugger takes over. A two-bit mode field tells the debugger whether the core is running or halted.

Top module: `trace_dbg_ctl`

## Requirements
- R1: After `por_n` is released, `cpu_mode` is 2'b00 (running), and `dbg_req`, `trace_hit` and `arm_err` are 0. Both control bits are clear.
- R2: A write with `wr_sel`=0 stores `wr_data` as the trace count. A write with `wr_sel`=1 stores `wr_data[0]` as trace-enable and `wr_data[1]` as debug-on-reset.
- R3: A cycle with `core_rst` high moves `cpu_mode` at the next edge to 2'b01 (debug) if debug-on-reset is set, and to 2'b00 otherwise. In both cases it drops `dbg_req` and cancels any armed trace. `core_rst` has priority over every other event.
- R4: `exit_cmd` while `cpu_mode` is 2'b01 sets `cpu_mode` to 2'b00 and clears `dbg_req` at the next edge. `exit_cmd` while running has no effect.
- R5: An exit with trace-enable set and a non-zero count N arms the trace. The (N+1)-th later retire strobe triggers a trace stop, and no earlier strobe does.
- R6: With `seq_bkpt_en` high at the exit, a count of zero arms the trace, and the first retire strobe triggers the stop.
- R7: With `seq_bkpt_en` low at the exit, a count of zero sets `arm_err` and does not arm, so later retire strobes raise no request.
- R8: Retire strobes count only while the trace is armed and the core is running. Idle cycles between strobes leave the count unchanged, and strobes during debug mode are ignored.
- R9: A trace stop sets `cpu_mode` to 2'b01, `dbg_req` to 1 and `trace_hit` to 1 at the edge after the triggering strobe. `dbg_req` holds until an exit or a core reset.
- R10: `trace_hit` and `arm_err` stay set until a cycle with `stat_clr` high clears them. If a set and `stat_clr` fall in the same cycle, the set wins.
- R11: An exit with trace-enable clear arms nothing, so retire strobes raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low block reset |
| core_rst | input | 1 | Processor reset, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the count, 1 selects the control bits |
| wr_data | input | CNT_W | Write data |
| seq_bkpt_en | input | 1 | Sequential-breakpoint operation enabled |
| retire | input | 1 | One instruction retired this cycle |
| exit_cmd | input | 1 | Debug-exit command |
| stat_clr | input | 1 | Clears trace_hit and arm_err |
| dbg_req | output | 1 | Request for the core to enter debug mode |
| trace_hit | output | 1 | The last debug entry was caused by the trace count |
| arm_err | output | 1 | An exit tried to arm with an illegal zero count |
| cpu_mode | output | 2 | 2'b00 running, 2'b01 debug |

## Verification
The expiring retire strobe can fall in the same cycle as `stat_clr`, and then setting `trace_hit` competes with clearing it. The bench arms a count of one, holds `stat_clr` high during the second strobe, and expects `trace_hit` to read 1 afterwards. A second collision pits `core_rst` against an armed trace. A reset in the middle of a count must leave later strobes without effect, and the bench judges this from `dbg_req` staying low.

// File: rtl/trace_dbg_pkg.sv
package trace_dbg_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_DEBUG = 2'b01
    } mode_e;

    typedef struct packed {
        logic  tme;   // trace enable
        logic  dor;   // debug on core reset
        mode_e mode;
        logic  req;
    } ctl_state_t;

endpackage

// File: rtl/trace_cnt.sv
module trace_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         arm_i,
    input  logic         disarm_i,
    input  logic [W-1:0] load_i,
    input  logic         retire_i,
    output logic         armed_o,
    output logic         fire_o
);

    typedef struct packed {
        logic         armed;
        logic [W-1:0] cnt;
    } cnt_state_t;

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    cnt_state_t s_d, s_q;
    logic       at_zero;

    assign at_zero = (s_q.cnt == ZERO);
    assign fire_o  = s_q.armed && retire_i && at_zero && !disarm_i;
    assign armed_o = s_q.armed;

    always_comb begin
        s_d = s_q;
        if (disarm_i) begin
            s_d.armed = 1'b0;
        end else if (arm_i) begin
            s_d.armed = 1'b1;
            s_d.cnt   = load_i;
        end else if (s_q.armed && retire_i) begin
            if (at_zero) s_d.armed = 1'b0;
            else         s_d.cnt   = s_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/trace_flags.sv
module trace_flags (
    input  logic clk,
    input  logic por_n,
    input  logic set_hit_i,
    input  logic set_err_i,
    input  logic clr_i,
    output logic hit_o,
    output logic err_o
);

    typedef struct packed {
        logic hit;
        logic err;
    } flag_state_t;

    flag_state_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clr_i) f_d = '0;
        if (set_hit_i) f_d.hit = 1'b1;
        if (set_err_i) f_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign hit_o = f_q.hit;
    assign err_o = f_q.err;

endmodule

// File: rtl/trace_dbg_ctl.sv
module trace_dbg_ctl
    import trace_dbg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             core_rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             seq_bkpt_en,
    input  logic             retire,
    input  logic             exit_cmd,
    input  logic             stat_clr,
    output logic             dbg_req,
    output logic             trace_hit,
    output logic             arm_err,
    output logic [1:0]       cpu_mode
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    ctl_state_t       st_d, st_q;
    logic [CNT_W-1:0] load_d, load_q;
    logic             leaving, arm, bad_arm, fire, armed;
    logic             dor_q;

    assign leaving = exit_cmd && (st_q.mode == MODE_DEBUG) && !core_rst;
    assign bad_arm = leaving && st_q.tme && (load_q == CNT_ZERO) && !seq_bkpt_en;
    assign arm     = leaving && st_q.tme && !bad_arm;

    trace_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .arm_i    (arm),
        .disarm_i (core_rst),
        .load_i   (load_q),
        .retire_i (retire && (st_q.mode == MODE_RUN)),
        .armed_o  (armed),
        .fire_o   (fire)
    );

    trace_flags u_flags (
        .clk       (clk),
        .por_n     (por_n),
        .set_hit_i (fire),
        .set_err_i (bad_arm),
        .clr_i     (stat_clr),
        .hit_o     (trace_hit),
        .err_o     (arm_err)
    );

    always_comb begin
        st_d   = st_q;
        load_d = load_q;
        if (wr_en) begin
            if (wr_sel) begin
                st_d.tme = wr_data[0];
                st_d.dor = wr_data[1];
            end else begin
                load_d = wr_data;
            end
        end
        if (core_rst) begin
            st_d.mode = st_q.dor ? MODE_DEBUG : MODE_RUN;
            st_d.req  = 1'b0;
        end else if (leaving) begin
            st_d.mode = MODE_RUN;
            st_d.req  = 1'b0;
        end else if (fire) begin
            st_d.mode = MODE_DEBUG;
            st_d.req  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q   <= '{tme: 1'b0, dor: 1'b0, mode: MODE_RUN, req: 1'b0};
            load_q <= '0;
        end else begin
            st_q   <= st_d;
            load_q <= load_d;
        end
    end

    assign dor_q    = st_q.dor;
    assign dbg_req  = st_q.req;
    assign cpu_mode = st_q.mode;

endmodule

// File: rtl/trace_dbg_chk.sv
module trace_dbg_chk (
    input logic       clk,
    input logic       por_n,
    input logic       core_rst,
    input logic       exit_cmd,
    input logic       stat_clr,
    input logic       dor,
    input logic       dbg_req,
    input logic       trace_hit,
    input logic [1:0] cpu_mode
);

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!por_n)
        cpu_mode == 2'b00 || cpu_mode == 2'b01);                          // R9

    AST_REQ_IN_DEBUG: assert property (@(posedge clk) disable iff (!por_n)
        dbg_req |-> cpu_mode == 2'b01);                                    // R9

    AST_REQ_MARKS_HIT: assert property (@(posedge clk) disable iff (!por_n)
        $rose(dbg_req) |-> trace_hit);                                     // R9

    AST_RESET_TO_DEBUG: assert property (@(posedge clk) disable iff (!por_n)
        (core_rst && dor) |=> (cpu_mode == 2'b01 && !dbg_req));            // R3

    AST_RESET_TO_RUN: assert property (@(posedge clk) disable iff (!por_n)
        (core_rst && !dor) |=> (cpu_mode == 2'b00 && !dbg_req));           // R3

    AST_EXIT_RUNS: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_mode == 2'b01 && exit_cmd && !core_rst) |=> (cpu_mode == 2'b00 && !dbg_req)); // R4

    AST_DEBUG_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        (cpu_mode == 2'b01 && !exit_cmd && !core_rst) |=> (cpu_mode == 2'b01 && $stable(dbg_req))); // R9

    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (trace_hit && !stat_clr) |=> trace_hit);                           // R10

endmodule

bind trace_dbg_ctl trace_dbg_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .core_rst  (core_rst),
    .exit_cmd  (exit_cmd),
    .stat_clr  (stat_clr),
    .dor       (dor_q),
    .dbg_req   (dbg_req),
    .trace_hit (trace_hit),
    .cpu_mode  (cpu_mode)
);

// File: tb/trace_dbg_ctl_test.sv
module trace_dbg_ctl_test;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          core_rst = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic          seq_bkpt_en = 1'b0, retire = 1'b0, exit_cmd = 1'b0, stat_clr = 1'b0;
    logic          dbg_req, trace_hit, arm_err;
    logic [1:0]    cpu_mode;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trace_dbg_ctl #(.CNT_W(CW)) uut (
        .clk(clk), .por_n(por_n), .core_rst(core_rst), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .seq_bkpt_en(seq_bkpt_en),
        .retire(retire), .exit_cmd(exit_cmd), .stat_clr(stat_clr),
        .dbg_req(dbg_req), .trace_hit(trace_hit), .arm_err(arm_err),
        .cpu_mode(cpu_mode)
    );

    // vector: count[25:10], seq[9], expect_err[8], strobes_to_stop[7:0]
    localparam int NV = 6;
    localparam logic [25:0] VEC [NV] = '{
        {16'd1, 1'b0, 1'b0, 8'd2},
        {16'd3, 1'b0, 1'b0, 8'd4},
        {16'd0, 1'b1, 1'b0, 8'd1},
        {16'd0, 1'b0, 1'b1, 8'd4},
        {16'd5, 1'b1, 1'b0, 8'd6},
        {16'd2, 1'b0, 1'b0, 8'd3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // all drives happen 1 time unit after a rising edge
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic sel, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pulse_rst();
        core_rst = 1'b1; tick(); core_rst = 1'b0;
    endtask

    task automatic do_exit();
        exit_cmd = 1'b1; tick(); exit_cmd = 1'b0;
    endtask

    task automatic ret();
        retire = 1'b1; tick(); retire = 1'b0;
    endtask

    task automatic clr();
        stat_clr = 1'b1; tick(); stat_clr = 1'b0;
    endtask

    // park in debug through reset, load count, enable trace, exit
    task automatic arm_with(input logic [CW-1:0] n, input logic seq, input logic tme);
        wr(1'b1, CW'(2));
        pulse_rst();
        wr(1'b0, n);
        wr(1'b1, {14'd0, 1'b1, tme});
        seq_bkpt_en = seq;
        do_exit();
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        #12 por_n = 1'b1;
        tick();
        chk("R1 mode", cpu_mode, 2'b00);
        chk("R1 req", dbg_req, 0);
        chk("R1 hit", trace_hit, 0);
        chk("R1 err", arm_err, 0);
        pulse_rst();
        chk("R1 dor clear after por", cpu_mode, 2'b00);

        for (int v = 0; v < NV; v++) begin
            logic [CW-1:0] n;
            logic          sq, er;
            int            k;
            n = VEC[v][25:10]; sq = VEC[v][9]; er = VEC[v][8]; k = int'(VEC[v][7:0]);
            clr();
            arm_with(n, sq, 1'b1);
            chk("R2 R4 exit runs", cpu_mode, 2'b00);
            chk("R7 arm_err", arm_err, er);
            for (int i = 0; i < k; i++) begin
                if (i == k - 1) chk("R5 R6 R8 no early stop", dbg_req, 0);
                if (i % 2 == 1) begin tick(); tick(); end  // idle gaps
                ret();
            end
            if (er) begin
                chk("R7 no request", dbg_req, 0);
            end else begin
                chk("R9 req", dbg_req, 1);
                chk("R9 mode", cpu_mode, 2'b01);
                chk("R9 hit", trace_hit, 1);
            end
        end

        // R8: strobes during debug mode are ignored
        ret(); ret();
        chk("R8 debug holds", cpu_mode, 2'b01);
        chk("R9 req held", dbg_req, 1);
        do_exit();
        chk("R4 exit clears req", dbg_req, 0);
        chk("R10 hit sticky over exit", trace_hit, 1);
        do_exit();
        chk("R4 exit while running ignored", cpu_mode, 2'b00);
        clr();
        chk("R10 clear hit", trace_hit, 0);

        // R11: trace enable clear
        arm_with(16'd0, 1'b1, 1'b0);
        ret(); ret(); ret();
        chk("R11 no arm", dbg_req, 0);

        // R10: set and clear in the same cycle, set wins
        arm_with(16'd1, 1'b0, 1'b1);
        ret();
        stat_clr = 1'b1; retire = 1'b1; tick(); stat_clr = 1'b0; retire = 1'b0;
        chk("R10 set wins", trace_hit, 1);
        chk("R9 req on collision", dbg_req, 1);

        // R3: core reset cancels armed trace and with dor=0 runs
        clr();
        arm_with(16'd2, 1'b0, 1'b1);
        ret();
        wr(1'b1, CW'(1));
        pulse_rst();
        chk("R3 reset without dor runs", cpu_mode, 2'b00);
        ret(); ret(); ret(); ret();
        chk("R3 cancelled trace", dbg_req, 0);
        chk("R3 no hit", trace_hit, 0);

        // R3: core reset wins over a firing strobe
        arm_with(16'd0, 1'b1, 1'b1);
        core_rst = 1'b1; retire = 1'b1; tick(); core_rst = 1'b0; retire = 1'b0;
        chk("R3 reset priority mode", cpu_mode, 2'b01);
        chk("R3 reset priority req", dbg_req, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule